// File: doc/BRIEF.md
# Packed SIMD Lane ALU

This block is a registered lane ALU for 64-bit media words. Each word is treated either as eight signed 8-bit lanes or as four signed 16-bit lanes. On every cycle with `valid_i` high it combines a first source vector with a second operand and writes the outcome into a result register or into a per-lane condition register. It also records whether the operand-select code named an unsupported lane width.

A single 5-bit select code does two jobs. It sets the lane width, and it decides where the second operand comes from: one element of the second vector copied to every lane, the second vector used lane by lane, or the 5-bit immediate copied to every lane. The condition register is written by the compare operations. The pick operations read it back to merge two vectors lane by lane. Lane 0 sits in the least significant bits of every 64-bit word. Lane i of the condition vector is bit i.

Top module: `simd_lane_alu`

## Requirements
- R1: Select bit 0 = 0 selects 8-bit lanes. Select bits [1:0] = 01 select 16-bit lanes. Select bits [1:0] = 11 are illegal. On each valid cycle, `illegal_o` is updated one clock later to show whether the code was illegal. An illegal cycle leaves `result_o` and `cond_o` unchanged.
- R2: When select bit 4 = 0, one element of `src_b_i` is copied to every lane. The element index is select[3:1] for 8-bit lanes and select[3:2] for 16-bit lanes. Lane 0 is the least significant lane.
- R3: When select bits [4:3] = 10, `src_b_i` is used lane by lane. When select bits [4:3] = 11, the zero-extended 5-bit `imm_i` is copied to every lane.
- R4: Add (op 0) and multiply (op 2) are signed. They clamp each lane to 0x7F/0x80 for 8-bit lanes and to 0x7FFF/0x8000 for 16-bit lanes.
- R5: Subtract (op 1), AND (op 3), OR (op 4), NOR (op 5) and XOR (op 6) wrap modulo the lane width and never saturate.
- R6: Minimum (op 7) and maximum (op 8) compare lanes as signed values.
- R7: Compare equal (op 9), less-than (op 10) and less-or-equal (op 11) are signed. They write bit i of `cond_o` for lane i, clear the unused upper four bits in 16-bit mode, and leave `result_o` unchanged.
- R8: Pick-true (op 12) takes the first-source lane where the stored condition bit is 1 and the second operand elsewhere. Pick-false (op 13) does the reverse. Neither changes `cond_o`.
- R9: Shift-left (op 14), logical shift-right (op 15) and arithmetic shift-right (op 16) use the second-operand lane as the count. The count is masked to 3 bits for 8-bit lanes and to 4 bits for 16-bit lanes. Logical shifts fill with zeros. The arithmetic right shift fills with the sign bit.
- R10: Reset clears all outputs. A cycle with `valid_i` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Execute this cycle's operation |
| op_i | input | 5 | Operation code |
| sel_i | input | 5 | Lane width and second-operand select code |
| imm_i | input | 5 | Immediate broadcast value |
| src_a_i | input | 64 | First source vector |
| src_b_i | input | 64 | Second source vector |
| result_o | output | 64 | Registered vector result |
| cond_o | output | 8 | Registered per-lane condition bits |
| illegal_o | output | 1 | Last valid select code had an unsupported width |

## Verification
All state lives in the three output registers, so any wrong internal state shows at the ports on the next clock edge. The one exception is a bad condition bit. The condition register is itself an output, but its effect on data appears only when a later pick operation uses it. The random stream therefore mixes compares and picks. This lets a corrupted condition bit show up one valid cycle after it is written, as a wrong lane in `result_o`. Errors in lane width and operand routing appear in the very next result, because every lane of every operation is checked against an independent model.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [4:0]        sel_i,
  input  logic [4:0]        imm_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W/8-1:0] cond_o,
  output logic              illegal_o
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_SUB = 5'd1,  OP_MUL = 5'd2,  OP_AND = 5'd3;
  localparam logic [4:0] OP_OR  = 5'd4,  OP_NOR = 5'd5,  OP_XOR = 5'd6,  OP_MIN = 5'd7;
  localparam logic [4:0] OP_MAX = 5'd8,  OP_CEQ = 5'd9,  OP_CLT = 5'd10, OP_CLE = 5'd11;
  localparam logic [4:0] OP_PKT = 5'd12, OP_PKF = 5'd13, OP_SLL = 5'd14, OP_SRL = 5'd15;
  localparam logic [4:0] OP_SRA = 5'd16;

  logic [DATA_W-1:0] res_q, opnd_b, byte_vec, half_vec;
  logic [NB-1:0]     cond_q, byte_cnd;
  logic [NH-1:0]     half_cnd;
  logic              ill_q;

  wire byte_mode = ~sel_i[0];
  wire half_mode = sel_i[1:0] == 2'b01;
  wire illegal   = sel_i[1:0] == 2'b11;
  wire is_cmp    = (op_i == OP_CEQ) || (op_i == OP_CLT) || (op_i == OP_CLE);

  wire [7:0]  elem_b8  = src_b_i[sel_i[3:1]*8 +: 8];
  wire [15:0] elem_b16 = src_b_i[sel_i[3:2]*16 +: 16];

  always_comb begin
    if (!sel_i[4])
      opnd_b = byte_mode ? {NB{elem_b8}} : {NH{elem_b16}};
    else if (!sel_i[3])
      opnd_b = src_b_i;
    else
      opnd_b = byte_mode ? {NB{3'b000, imm_i}} : {NH{11'b0, imm_i}};
  end

  // returns {condition bit, 16-bit lane result}; byte lanes arrive sign-extended
  function automatic logic [16:0] lane_calc(input logic [4:0] op,
                                            input logic signed [15:0] a,
                                            input logic signed [15:0] b,
                                            input logic wide,
                                            input logic cflag);
    logic signed [31:0] s, hi, lo;
    logic [3:0]  cnt;
    logic [15:0] r;
    logic        c;
    hi  = wide ? 32'sd32767 : 32'sd127;
    lo  = wide ? -32'sd32768 : -32'sd128;
    cnt = wide ? b[3:0] : {1'b0, b[2:0]};
    s   = '0;
    r   = '0;
    c   = 1'b0;
    case (op)
      OP_ADD, OP_MUL: begin
        s = (op == OP_ADD) ? (32'(a) + 32'(b)) : (32'(a) * 32'(b));
        if (s > hi)      r = hi[15:0];
        else if (s < lo) r = lo[15:0];
        else             r = s[15:0];
      end
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_NOR:  r = ~(a | b);
      OP_XOR:  r = a ^ b;
      OP_MIN:  r = (a < b) ? a : b;
      OP_MAX:  r = (a < b) ? b : a;
      OP_CEQ:  c = a == b;
      OP_CLT:  c = a < b;
      OP_CLE:  c = a <= b;
      OP_PKT:  r = cflag ? a : b;
      OP_PKF:  r = cflag ? b : a;
      OP_SLL:  r = a << cnt;
      OP_SRL:  r = wide ? (a >> cnt) : ({8'b0, a[7:0]} >> cnt);
      OP_SRA:  r = a >>> cnt;
      default: r = '0;
    endcase
    return {c, r};
  endfunction

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [16:0] o;
    assign o = lane_calc(op_i, {{8{src_a_i[g*8+7]}}, src_a_i[g*8 +: 8]},
                         {{8{opnd_b[g*8+7]}}, opnd_b[g*8 +: 8]}, 1'b0, cond_q[g]);
    assign byte_vec[g*8 +: 8] = o[7:0];
    assign byte_cnd[g]        = o[16];
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [16:0] o;
    assign o = lane_calc(op_i, src_a_i[h*16 +: 16], opnd_b[h*16 +: 16], 1'b1, cond_q[h]);
    assign half_vec[h*16 +: 16] = o[15:0];
    assign half_cnd[h]          = o[16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      cond_q <= '0;
      ill_q  <= 1'b0;
    end else if (valid_i) begin
      ill_q <= illegal;
      if (!illegal) begin
        if (is_cmp) cond_q <= byte_mode ? byte_cnd : {{(NB-NH){1'b0}}, half_cnd};
        else        res_q  <= byte_mode ? byte_vec : half_vec;
      end
    end
  end

  assign result_o  = res_q;
  assign cond_o    = cond_q;
  assign illegal_o = ill_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o) && $stable(cond_o) && $stable(illegal_o)); // R10
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && sel_i[1:0] == 2'b11 |=> $stable(result_o) && $stable(cond_o)); // R1
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> illegal_o == $past(sel_i[1:0] == 2'b11)); // R1
  AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == OP_CEQ || op_i == OP_CLT || op_i == OP_CLE) |=> $stable(result_o)); // R7
  AST_HALF_CMP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && half_mode && (op_i == OP_CEQ || op_i == OP_CLT || op_i == OP_CLE)
    |=> cond_o[NB-1:NH] == '0); // R7
  AST_PICK_KEEPS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == OP_PKT || op_i == OP_PKF) |=> $stable(cond_o)); // R8
endmodule

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0, sel_i = '0, imm_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic [63:0] result_o;
  logic [7:0]  cond_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_res = '0;
  logic [7:0]  m_cond = '0;
  logic        m_ill = 1'b0;

  always #5 clk = ~clk;

  simd_lane_alu dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .sel_i(sel_i),
    .imm_i(imm_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .result_o(result_o), .cond_o(cond_o), .illegal_o(illegal_o)
  );

  function automatic int lane_s(logic [63:0] v, int i, int w);
    if (w == 8) return int'($signed(v[i*8 +: 8]));
    return int'($signed(v[i*16 +: 16]));
  endfunction

  function automatic string tag_of(logic [4:0] op, logic [4:0] sel);
    if (sel[1:0] == 2'b11) return "R1";
    case (op)
      5'd0, 5'd2: return "R4";
      5'd1, 5'd3, 5'd4, 5'd5, 5'd6: return "R5";
      5'd7, 5'd8: return "R6";
      5'd9, 5'd10, 5'd11: return "R7";
      5'd12, 5'd13: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [4:0] op, input logic [4:0] sel, input logic [4:0] imm,
                       input logic [63:0] a, input logic [63:0] b);
    int w, n;
    logic [63:0] nr;
    logic [7:0]  nc;
    m_ill = (sel[1:0] == 2'b11);
    if (m_ill) return;
    w  = sel[0] ? 16 : 8;
    n  = 64 / w;
    nr = m_res;
    nc = '0;
    for (int i = 0; i < n; i++) begin
      int av, bv, x, hi, lo, cnt;
      av = lane_s(a, i, w);
      if (!sel[4])      bv = lane_s(b, (w == 8) ? int'(sel[3:1]) : int'(sel[3:2]), w);
      else if (!sel[3]) bv = lane_s(b, i, w);
      else              bv = int'(imm);
      hi  = (w == 8) ? 127 : 32767;
      lo  = -hi - 1;
      cnt = bv & (w - 1);
      x   = 0;
      case (op)
        5'd0:  begin x = av + bv; if (x > hi) x = hi; if (x < lo) x = lo; end
        5'd2:  begin x = av * bv; if (x > hi) x = hi; if (x < lo) x = lo; end
        5'd1:  x = av - bv;
        5'd3:  x = av & bv;
        5'd4:  x = av | bv;
        5'd5:  x = ~(av | bv);
        5'd6:  x = av ^ bv;
        5'd7:  x = (av < bv) ? av : bv;
        5'd8:  x = (av > bv) ? av : bv;
        5'd9:  nc[i] = (av == bv);
        5'd10: nc[i] = (av < bv);
        5'd11: nc[i] = (av <= bv);
        5'd12: x = m_cond[i] ? av : bv;
        5'd13: x = m_cond[i] ? bv : av;
        5'd14: x = av << cnt;
        5'd15: x = (av & ((1 << w) - 1)) >> cnt;
        default: x = av >>> cnt;
      endcase
      for (int k = 0; k < w; k++) nr[i*w + k] = x[k];
    end
    if (op == 5'd9 || op == 5'd10 || op == 5'd11) m_cond = nc;
    else m_res = nr;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (result_o !== m_res || cond_o !== m_cond || illegal_o !== m_ill) begin
      errors++;
      $display("FAIL %s res=%h exp=%h cond=%h exp=%h ill=%b exp=%b",
               tag, result_o, m_res, cond_o, m_cond, illegal_o, m_ill);
    end
  endtask

  task automatic run_op(input logic [4:0] op, input logic [4:0] sel, input logic [4:0] imm,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
    @(negedge clk);
    op_i = op; sel_i = sel; imm_i = imm; src_a_i = a; src_b_i = b; valid_i = 1'b1;
    model(op, sel, imm, a, b);
    @(negedge clk);
    valid_i = 1'b0;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1'b1;

    // R4 byte saturation, vector operand (sel 10110)
    run_op(5'd0, 5'b10110, 5'd0, 64'h0000_0000_0000_807F, 64'h0000_0000_0000_FF01, "R4 add8 sat");
    run_op(5'd2, 5'b10101, 5'd0, 64'h0000_C000_0000_4000, 64'h0000_0004_0000_0004, "R4 mul16 sat");
    run_op(5'd1, 5'b10110, 5'd0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0001, "R5 sub8 wrap");
    // R2 broadcast element 7 in byte mode, element 3 in halfword mode
    run_op(5'd4, 5'b01110, 5'd0, 64'h0, 64'hA500_0000_0000_0000, "R2 byte elem7");
    run_op(5'd4, 5'b01101, 5'd0, 64'h0, 64'h1234_0000_0000_5678, "R2 half elem3");
    // R3 immediate broadcast
    run_op(5'd6, 5'b11110, 5'd31, 64'h0102_0304_0506_0708, 64'h0, "R3 imm byte");
    // R9 shift corners: count 9 masks to 1 in byte mode
    run_op(5'd16, 5'b11110, 5'd7, 64'h8080_8080_8080_8080, 64'h0, "R9 sra8");
    run_op(5'd15, 5'b11110, 5'd7, 64'h8080_8080_8080_8080, 64'h0, "R9 srl8");
    run_op(5'd14, 5'b11110, 5'd9, 64'h8181_8181_8181_8181, 64'h0, "R9 sll8 mask");
    run_op(5'd15, 5'b11101, 5'd17, 64'h8000_8000_8000_8000, 64'h0, "R9 srl16 mask");
    // R6 signed min
    run_op(5'd7, 5'b10110, 5'd0, 64'h7F80_7F80_7F80_7F80, 64'h807F_807F_807F_807F, "R6 min8");
    // R7 then R8
    run_op(5'd10, 5'b10101, 5'd0, 64'h8000_0001_7FFF_0000, 64'h0000_0001_8000_0001, "R7 lt16");
    run_op(5'd12, 5'b10101, 5'd0, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, "R8 pickt16");
    run_op(5'd13, 5'b10101, 5'd0, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, "R8 pickf16");
    // R1 illegal codes
    run_op(5'd0, 5'b00011, 5'd0, 64'hFFFF, 64'hFFFF, "R1 illegal 32");
    run_op(5'd9, 5'b10111, 5'd0, 64'h0, 64'h0, "R1 illegal 64");
    run_op(5'd3, 5'b10110, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_0F0F_0F0F_0F0F, "R1 legal after");

    // R10 idle cycles with changing inputs
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      op_i = 5'(j); sel_i = 5'b10110; src_a_i = {$urandom, $urandom}; src_b_i = {$urandom, $urandom};
      @(negedge clk);
      compare("R10 idle");
    end

    for (int j = 0; j < 600; j++) begin
      logic [4:0] op, sel;
      op  = 5'($urandom_range(16));
      sel = 5'($urandom);
      run_op(op, sel, 5'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, tag_of(op, sel));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule